// File: doc/BRIEF.md
# Cache Event Counter Bank

This block is a bank of 64-bit performance counters for a shared cache. The cache presents one pulse vector per event group every cycle: four groups, holding 20, 19, 14 and 1 events. Each counter is steered by its own 64-bit select register. That register names one group and carries a mask of the events in that group. Every cycle the counter adds the number of masked events that fired.

Software reaches the bank through a plain 32-bit register port. One address serves both reads and writes. Each 64-bit register appears as two words. The port also gives access to a 64-bit client filter register, which the bank only stores. The number of counters is a parameter from 1 to 64.

Top module: `cachemon_ctr_bank`

## Requirements
- R1: After reset, every select register, every counter, the filter register and the read data are zero.
- R2: Select bits 7:0 hold a group number: 1 is the 20-event group, 2 the 19-event group, 3 the 14-event group and 4 the single-event group. Event n of that group is enabled by select bit n+8. A counter counts only events of the group it names.
- R3: Each cycle a counter adds the number of its enabled events that are high in that cycle, which can be more than one.
- R4: A group number of 0 or above 4 counts nothing. Mask bits above the size of the named group are ignored.
- R5: Select i sits at byte offset 0x2000+8i, counter i at 0x3000+8i and the filter at 0x2800. Address bit 2 picks the high word (1) or the low word (0), and address bits 1:0 are ignored.
- R6: When the read strobe is high at a clock edge, the read data captures the addressed word as it was before that edge. It holds that value until the next read.
- R7: A write replaces only the addressed 32-bit half. Writing zero to both halves of a counter clears it. A write to a counter takes precedence over that cycle's increment, which is dropped.
- R8: A select write takes effect from the next cycle, so events in the write cycle are counted under the old select. Writing zero to a select stops its counter.
- R9: The filter register reads back what was written and has no effect on counting.
- R10: Reads of unmapped offsets, or of select or counter slots at or above the configured count, return zero. Writes to them change nothing.
- R11: A counter counts across the full 64 bits, carrying from the low word into the high word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_rd_en | input | 1 | Read strobe for the register port |
| reg_addr | input | 14 | Byte offset, shared by reads and writes |
| reg_wdata | input | 32 | Write data word |
| reg_rdata | output | 32 | Registered read data word |
| ev_set1 | input | 20 | Event pulses, group 1 |
| ev_set2 | input | 19 | Event pulses, group 2 |
| ev_set3 | input | 14 | Event pulses, group 3 |
| ev_set4 | input | 1 | Event pulse, group 4 |

## Verification
A register write and event counting can land on the same counter in the same clock. For a counter, the write must win and that cycle's increment must vanish. For a select, the events in the write cycle must still be counted under the old select. The bench provokes both by holding event pulses high across the write strobe, and it judges the result by reading the counter back against hand-computed values. A long random phase mixes writes, reads and event traffic, and a behavioural model checks the read data on every clock.

// File: rtl/cachemon_pkg.sv
package cachemon_pkg;
  // event group sizes (behavioural: select bit n+8 enables event n)
  localparam int SET1_W  = 20;
  localparam int SET2_W  = 19;
  localparam int SET3_W  = 14;
  localparam int SET4_W  = 1;
  localparam int MAX_EV  = 20;
  localparam int INC_W   = $clog2(MAX_EV + 1);
  localparam int SEL_USE = MAX_EV + 8;
  localparam int AW      = 14;
  localparam int DW      = 32;
  localparam int RW      = 64;

  // address regions, decoded on reg_addr[13:9]
  localparam logic [4:0]  SEL_REGION = 5'b10000;
  localparam logic [4:0]  CNT_REGION = 5'b11000;
  // filter doubleword, decoded on reg_addr[13:3]
  localparam logic [10:0] FILT_DWORD = 11'h500;

  typedef struct packed {
    logic       sel;
    logic       cnt;
    logic       filt;
    logic       hi;
    logic [5:0] idx;
  } reg_hit_t;

  function automatic logic [RW-1:0] merge_word(logic [RW-1:0] cur, logic hi,
                                               logic [DW-1:0] w);
    logic [RW-1:0] r;
    r = cur;
    if (hi) r[RW-1:DW] = w;
    else    r[DW-1:0]  = w;
    return r;
  endfunction

  function automatic logic [DW-1:0] pick_word(logic [RW-1:0] v, logic hi);
    return hi ? v[RW-1:DW] : v[DW-1:0];
  endfunction
endpackage

// File: rtl/cachemon_addr_dec.sv
module cachemon_addr_dec
  import cachemon_pkg::*;
(
  input  logic [AW-1:0] addr,
  output reg_hit_t      hit
);
  logic unused_lsb;
  assign unused_lsb = ^addr[1:0];

  always_comb begin
    hit      = '0;
    hit.hi   = addr[2];
    hit.idx  = addr[8:3];
    hit.sel  = (addr[13:9] == SEL_REGION);
    hit.cnt  = (addr[13:9] == CNT_REGION);
    hit.filt = (addr[13:3] == FILT_DWORD);
  end
endmodule

// File: rtl/cachemon_ev_tally.sv
module cachemon_ev_tally
  import cachemon_pkg::*;
(
  input  logic [SEL_USE-1:0] sel,
  input  logic [SET1_W-1:0]  ev1,
  input  logic [SET2_W-1:0]  ev2,
  input  logic [SET3_W-1:0]  ev3,
  input  logic [SET4_W-1:0]  ev4,
  output logic [INC_W-1:0]   inc
);
  logic [MAX_EV-1:0] armed;

  always_comb begin
    case (sel[7:0])
      8'd1:    armed = MAX_EV'(ev1 & sel[8 +: SET1_W]);
      8'd2:    armed = MAX_EV'(ev2 & sel[8 +: SET2_W]);
      8'd3:    armed = MAX_EV'(ev3 & sel[8 +: SET3_W]);
      8'd4:    armed = MAX_EV'(ev4 & sel[8 +: SET4_W]);
      default: armed = '0;
    endcase
  end

  always_comb begin
    inc = '0;
    for (int b = 0; b < MAX_EV; b++) begin
      inc = inc + INC_W'(armed[b]);
    end
  end
endmodule

// File: rtl/cachemon_ctr_slot.sv
module cachemon_ctr_slot
  import cachemon_pkg::*;
#(
  parameter int SLOT_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_hit_t          hit,
  input  logic [DW-1:0]     wdata,
  input  logic [SET1_W-1:0] ev1,
  input  logic [SET2_W-1:0] ev2,
  input  logic [SET3_W-1:0] ev3,
  input  logic [SET4_W-1:0] ev4,
  output logic [DW-1:0]     rd_word,
  output logic [RW-1:0]     sel_q,
  output logic [RW-1:0]     cnt_q
);
  logic             id_match, sel_we, cnt_we, sel_en, cnt_en;
  logic [RW-1:0]    sel_d, cnt_d;
  logic [INC_W-1:0] inc;
  logic             unused_filt;

  assign unused_filt = hit.filt;
  assign id_match    = (hit.idx == 6'(SLOT_ID));
  assign sel_we      = wr_en & hit.sel & id_match;
  assign cnt_we      = wr_en & hit.cnt & id_match;

  cachemon_ev_tally u_tally (
    .sel (sel_q[SEL_USE-1:0]),
    .ev1 (ev1),
    .ev2 (ev2),
    .ev3 (ev3),
    .ev4 (ev4),
    .inc (inc)
  );

  // next state: a register write overrides the cycle's increment
  always_comb begin
    sel_d  = merge_word(sel_q, hit.hi, wdata);
    sel_en = sel_we;
    if (cnt_we) cnt_d = merge_word(cnt_q, hit.hi, wdata);
    else        cnt_d = cnt_q + RW'(inc);
    cnt_en = cnt_we | (inc != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      if (sel_en) sel_q <= sel_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  always_comb begin
    rd_word = '0;
    if (id_match && hit.sel) rd_word = pick_word(sel_q, hit.hi);
    if (id_match && hit.cnt) rd_word = pick_word(cnt_q, hit.hi);
  end
endmodule

// File: rtl/cachemon_ctr_bank.sv
module cachemon_ctr_bank
  import cachemon_pkg::*;
#(
  parameter int NUM_CTR = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_rd_en,
  input  logic [13:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [19:0] ev_set1,
  input  logic [18:0] ev_set2,
  input  logic [13:0] ev_set3,
  input  logic [0:0]  ev_set4
);
  reg_hit_t                    hit;
  logic [NUM_CTR-1:0][DW-1:0]  slot_rd;
  logic [NUM_CTR-1:0][RW-1:0]  slot_sel;
  logic [NUM_CTR-1:0][RW-1:0]  slot_cnt;
  logic [RW-1:0]               filt_q, filt_d;
  logic                        filt_en;
  logic [DW-1:0]               rd_mux, rdata_q;

  cachemon_addr_dec u_dec (
    .addr (reg_addr),
    .hit  (hit)
  );

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_slot
    cachemon_ctr_slot #(.SLOT_ID(i)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .hit     (hit),
      .wdata   (reg_wdata),
      .ev1     (ev_set1),
      .ev2     (ev_set2),
      .ev3     (ev_set3),
      .ev4     (ev_set4),
      .rd_word (slot_rd[i]),
      .sel_q   (slot_sel[i]),
      .cnt_q   (slot_cnt[i])
    );
  end

  always_comb begin
    filt_en = reg_wr_en & hit.filt;
    filt_d  = merge_word(filt_q, hit.hi, reg_wdata);
  end

  always_comb begin
    rd_mux = hit.filt ? pick_word(filt_q, hit.hi) : '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      rd_mux = rd_mux | slot_rd[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (filt_en)   filt_q  <= filt_d;
      if (reg_rd_en) rdata_q <= rd_mux;
    end
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/cachemon_ctr_bank_chk.sv
module cachemon_ctr_bank_chk #(
  parameter int NUM_CTR = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        reg_wr_en,
  input logic                        reg_rd_en,
  input logic [13:0]                 reg_addr,
  input logic [31:0]                 reg_wdata,
  input logic [31:0]                 reg_rdata,
  input logic [NUM_CTR-1:0][63:0]    slot_sel,
  input logic [NUM_CTR-1:0][63:0]    slot_cnt
);
  logic unused_chk;
  assign unused_chk = ^{reg_addr[1:0], slot_sel};

  // R6: read data only moves on a read strobe
  p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_en |=> $stable(reg_rdata));

  // R10: offsets below 0x2000 read as zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && !reg_addr[13]) |=> (reg_rdata == 32'd0));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    // R4: a group number of zero holds the counter
    p_idle_group_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr_en && slot_sel[i][7:0] == 8'd0) |=> (slot_cnt[i] == $past(slot_cnt[i])));

    // R3: no cycle adds more than the largest group size
    p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr_en |=> ((slot_cnt[i] - $past(slot_cnt[i])) <= 64'd20));

    // R7: a zero write to the low word clears it despite events
    p_clear_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr[13:2] == 12'(12'hC00 + 2*i) && reg_wdata == 32'd0)
        |=> (slot_cnt[i][31:0] == 32'd0));
  end
endmodule

bind cachemon_ctr_bank cachemon_ctr_bank_chk #(.NUM_CTR(NUM_CTR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_rd_en (reg_rd_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .slot_sel  (slot_sel),
  .slot_cnt  (slot_cnt)
);

// File: tb/cachemon_ctr_bank_tb.sv
module cachemon_ctr_bank_tb;
  localparam int NC = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [13:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [19:0] ev1;
  logic [18:0] ev2;
  logic [13:0] ev3;
  logic [0:0]  ev4;

  int    vectors = 0;
  int    fails   = 0;
  int    cyc     = 0;
  bit    done    = 0;
  string cur_req = "R1";

  logic [63:0] m_sel [NC];
  logic [63:0] m_cnt [NC];
  logic [63:0] m_filt;
  logic [31:0] m_rdata;

  always #10 clk = ~clk;

  cachemon_ctr_bank #(.NUM_CTR(NC)) u_dut (
    .clk (clk), .rst_n (rst_n), .reg_wr_en (wr_en), .reg_rd_en (rd_en),
    .reg_addr (addr), .reg_wdata (wdata), .reg_rdata (rdata),
    .ev_set1 (ev1), .ev_set2 (ev2), .ev_set3 (ev3), .ev_set4 (ev4)
  );

  // kind: 0 none, 1 select, 2 counter, 3 filter; returns kind*256+index
  function automatic int decode(logic [13:0] a);
    int off;
    off = int'(a) & 'h3FF8;
    if (off >= 'h2000 && off < 'h2000 + 8*NC) return 256 + (off - 'h2000) / 8;
    if (off >= 'h3000 && off < 'h3000 + 8*NC) return 512 + (off - 'h3000) / 8;
    if (off == 'h2800) return 768;
    return 0;
  endfunction

  function automatic int model_inc(logic [63:0] s);
    int sz, n;
    logic [31:0] ev;
    case (s[7:0])
      8'd1: begin sz = 20; ev = 32'(ev1); end
      8'd2: begin sz = 19; ev = 32'(ev2); end
      8'd3: begin sz = 14; ev = 32'(ev3); end
      8'd4: begin sz = 1;  ev = 32'(ev4); end
      default: return 0;
    endcase
    n = 0;
    for (int b = 0; b < sz; b++) if (ev[b] && s[8+b]) n++;
    return n;
  endfunction

  function automatic logic [63:0] put_half(logic [63:0] v, bit hi, logic [31:0] w);
    if (hi) v[63:32] = w; else v[31:0] = w;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin m_sel[i] = '0; m_cnt[i] = '0; end
      m_filt  = '0;
      m_rdata = '0;
    end else begin
      int d, k, ix;
      bit hi;
      logic [63:0] v;
      d  = decode(addr);
      k  = d / 256;
      ix = d % 256;
      hi = addr[2];
      if (rd_en) begin
        case (k)
          1: v = m_sel[ix];
          2: v = m_cnt[ix];
          3: v = m_filt;
          default: v = '0;
        endcase
        m_rdata = hi ? v[63:32] : v[31:0];
      end
      for (int i = 0; i < NC; i++) begin
        if (wr_en && k == 2 && ix == i) m_cnt[i] = put_half(m_cnt[i], hi, wdata);
        else m_cnt[i] = m_cnt[i] + 64'(model_inc(m_sel[i]));
      end
      if (wr_en && k == 1) m_sel[ix] = put_half(m_sel[ix], hi, wdata);
      if (wr_en && k == 3) m_filt = put_half(m_filt, hi, wdata);
    end
  end

  // per-clock comparison of the read port against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (rdata !== m_rdata) begin
        fails++;
        $display("FAIL %s per-clock rdata actual=%h expected=%h", cur_req, rdata, m_rdata);
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      finish_run();
    end
  end

  task automatic wr(logic [13:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [13:0] a);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk(logic [31:0] exp, string tag);
    vectors++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, exp);
    end
  endtask

  task automatic chk_read(logic [13:0] a, logic [31:0] exp, string tag);
    rd(a);
    chk(exp, tag);
  endtask

  task automatic fire(logic [19:0] a, logic [18:0] b, logic [13:0] c, logic d, int k);
    @(negedge clk); ev1 = a; ev2 = b; ev3 = c; ev4 = d;
    repeat (k) @(negedge clk);
    ev1 = '0; ev2 = '0; ev3 = '0; ev4 = '0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    ev1 = '0; ev2 = '0; ev3 = '0; ev4 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    cur_req = "R1";
    for (int i = 0; i < NC; i++) begin
      chk_read(14'(32'h2000 + 8*i), 32'd0, "R1 select");
      chk_read(14'(32'h3000 + 8*i), 32'd0, "R1 counter");
      chk_read(14'(32'h3004 + 8*i), 32'd0, "R1 counter hi");
    end
    chk_read(14'h2800, 32'd0, "R1 filter");

    // R3: popcount of simultaneous events
    cur_req = "R3";
    wr(14'h2000, 32'h0000_0701);
    fire('1, '0, '0, 1'b0, 5);
    chk_read(14'h3000, 32'd15, "R3 three events x5");
    fire(20'h00005, '0, '0, 1'b0, 4);
    chk_read(14'h3000, 32'd23, "R3 two events x4");

    // R2: group binding and bit n+8 mask
    cur_req = "R2";
    wr(14'h2008, 32'h0020_0103);
    chk_read(14'h2008, 32'h0020_0103, "R2 select readback");
    fire('1, '1, '1, 1'b1, 6);
    chk_read(14'h3008, 32'd12, "R2 group3 events 0,13");

    // R4: bad group number, mask bits past group size
    cur_req = "R4";
    wr(14'h2010, 32'hFFFF_FF05);
    fire('1, '1, '1, 1'b1, 4);
    chk_read(14'h3010, 32'd0, "R4 group 5");
    wr(14'h2018, 32'h0000_3F04);
    fire('1, '1, '1, 1'b1, 4);
    chk_read(14'h3018, 32'd4, "R4 group4 wide mask");
    wr(14'h201C, 32'hFFFF_FFFF);
    fire('1, '1, '1, 1'b1, 3);
    chk_read(14'h3018, 32'd7, "R4 upper select bits");

    // R11: carry into the high word
    cur_req = "R11";
    wr(14'h3018, 32'hFFFF_FFFE);
    fire('0, '0, '0, 1'b1, 3);
    chk_read(14'h3018, 32'd1, "R11 low after wrap");
    chk_read(14'h301C, 32'd1, "R11 high after carry");

    // R7: write beats increment, half write, clear
    cur_req = "R7";
    @(negedge clk); ev4 = 1'b1; wr_en = 1'b1; addr = 14'h3018; wdata = 32'd0;
    @(negedge clk); ev4 = 1'b0; wr_en = 1'b0;
    chk_read(14'h3018, 32'd0, "R7 increment dropped");
    chk_read(14'h301C, 32'd1, "R7 other half kept");
    wr(14'h301C, 32'd0);
    chk_read(14'h301C, 32'd0, "R7 cleared");

    // R8: select write timing and stop by zero
    cur_req = "R8";
    @(negedge clk); ev4 = 1'b1; wr_en = 1'b1; addr = 14'h2020; wdata = 32'h0000_0104;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk); ev4 = 1'b0;
    chk_read(14'h3020, 32'd1, "R8 new select next cycle");
    @(negedge clk); ev4 = 1'b1; wr_en = 1'b1; addr = 14'h2020; wdata = 32'd0;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk); ev4 = 1'b0;
    chk_read(14'h3020, 32'd2, "R8 old select in write cycle, then stop");

    // R9 / R5: filter storage, word select, ignored low address bits
    cur_req = "R9";
    wr(14'h2800, 32'h0000_ABCD);
    wr(14'h2804, 32'h0000_1234);
    chk_read(14'h2800, 32'h0000_ABCD, "R9 filter low");
    chk_read(14'h2804, 32'h0000_1234, "R9 filter high");
    chk_read(14'h2803, 32'h0000_ABCD, "R5 address bits 1:0 ignored");
    fire('1, '0, '0, 1'b0, 2);
    chk_read(14'h3000, 32'd80, "R9 counting unaffected by filter");

    // R6: hold between reads, read sees pre-write value
    cur_req = "R6";
    chk_read(14'h2804, 32'h0000_1234, "R6 read");
    wr(14'h2804, 32'd0);
    repeat (4) @(negedge clk);
    chk(32'h0000_1234, "R6 held without strobe");
    @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; addr = 14'h2800; wdata = 32'h5;
    @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
    chk(32'h0000_ABCD, "R6 read before same-cycle write");

    // R10: unmapped and out-of-range slots
    cur_req = "R10";
    wr(14'h2030, 32'h0000_0104);
    chk_read(14'h2030, 32'd0, "R10 select slot >= count");
    fire('0, '0, '0, 1'b1, 3);
    chk_read(14'h3030, 32'd0, "R10 counter slot >= count");
    wr(14'h1000, 32'hDEAD_BEEF);
    chk_read(14'h1000, 32'd0, "R10 unmapped low");
    chk_read(14'h2808, 32'd0, "R10 unmapped near filter");

    // random mix, judged by the per-clock model compare
    cur_req = "R8 random";
    for (int n = 0; n < 4000; n++) begin
      int op, kind, ix, hi;
      @(negedge clk);
      ev1 = 20'($urandom); ev2 = 19'($urandom); ev3 = 14'($urandom); ev4 = 1'($urandom);
      op = int'($urandom % 8); kind = int'($urandom % 3);
      ix = int'($urandom % 8); hi = int'($urandom % 2);
      addr = 14'((kind == 0 ? 'h2000 : kind == 1 ? 'h3000 : 'h2800) + 8*ix + 4*hi);
      wr_en = (op == 0);
      rd_en = (op >= 5);
      if (kind == 0 && hi == 0) wdata = {$urandom % (1 << 24), 8'($urandom % 6)};
      else if (kind == 1) wdata = (op == 0 && ix == 1) ? 32'hFFFF_FFF0 : $urandom;
      else wdata = $urandom;
    end
    @(negedge clk); wr_en = 0; rd_en = 0; ev1 = '0; ev2 = '0; ev3 = '0; ev4 = '0;
    cur_req = "R11 final";
    for (int i = 0; i < NC; i++) begin
      rd(14'(32'h3000 + 8*i));
      rd(14'(32'h3004 + 8*i));
      rd(14'(32'h2000 + 8*i));
    end
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule